// File: doc/BRIEF.md
# Serial Control Port Register Bank

This block is the serial slave that configures an audio converter's mode control register. A host frames each transfer with an active-low select line and a serial clock, and the block samples both in its own system clock domain, detecting serial clock edges from one clock to the next. Each frame opens with a header byte. The upper seven bits carry a chip address and must equal 0010000. The lowest bit selects direction: 0 for a write and 1 for a read. A write frame then carries one pointer byte, followed by any number of data bytes. A read frame carries no pointer byte. Instead, the block returns register contents, starting at the address left in the pointer by an earlier write frame.

The register bank holds a single implemented register at address 1. From bit 7 down to bit 0 it carries: a calibrate request, a soft-mute control, a five-bit mode-select field, and a power-down bit. These fields drive the top-level outputs directly. The calibrate bit clears itself when the calibration engine returns a done pulse. A sticky flag records that the serial interface has been selected: it is set by the first falling edge of the select line, and it is cleared by reset or by a power-down request.

Top module: `ctl_spi_regbank`

## Requirements
- R1: After reset the control register reads 0x01 (power-down set, calibrate, mute and mode-select clear), the interface-selected flag is 0, miso is 0, and the pointer holds address 1 with auto-increment off.
- R2: A falling edge of cs_n sets spi_mode on the next clock, and spi_mode then stays 1 across later frames and cs_n rises until R10 clears it or reset occurs.
- R3: Data is sampled on rising sck edges, MSB first. A write frame is a header {0010000, 0}, a pointer byte, then data bytes. A data byte addressed to 1 lands with bit 7 on cal_req, bit 6 on mute_ctl, bits 5:1 on mode_sel and bit 0 on pdn, in the clock after its eighth rising edge.
- R4: A frame whose header address differs from 0010000 changes no register and no pointer, and leaves miso at 0 until cs_n rises.
- R5: After a read header {0010000, 1}, the register at the pointer is driven on miso MSB first, with each bit changing after a falling sck edge. The first bit appears after the falling edge that follows the header's eighth rising edge.
- R6: Pointer bit 7 enables auto-increment. When it is set, the pointer advances by one after each data byte written or read. When it is clear, every byte of the frame uses the same address.
- R7: The pointer is 3 bits wide and wraps from 7 to 0. Addresses other than 1 read as 0x00, and writes to them are discarded.
- R8: A one-clock cal_done pulse clears cal_req and leaves the other fields unchanged.
- R9: When a write to address 1 commits in the same clock as a cal_done pulse, the written value is kept, including cal_req = 1.
- R10: A write that changes pdn from 0 to 1 clears spi_mode. Rewriting pdn = 1 while pdn is already 1 leaves spi_mode unchanged.
- R11: Pointer bits 6:3 are ignored: a pointer byte of 0x79 selects address 1 with auto-increment off.
- R12: miso is 0 whenever cs_n is high and whenever no read is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all serial lines are sampled with it |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low frame select |
| sck | input | 1 | Serial bit clock |
| mosi | input | 1 | Serial data from the host |
| cal_done | input | 1 | One-clock pulse marking the end of calibration |
| miso | output | 1 | Serial read data to the host |
| spi_mode | output | 1 | Sticky flag showing that the serial interface is selected |
| cal_req | output | 1 | Calibrate request field |
| mute_ctl | output | 1 | Soft-mute control field |
| mode_sel | output | 5 | Mode-select field |
| pdn | output | 1 | Power-down field |

## Verification
Two pairs of events can share a clock edge. The first pair is the commit of a data byte to the control register and a cal_done pulse. The bench raises cal_done on the same clock that the last rising sck edge of a byte is seen, so both land on one edge, and it expects the written value, including cal_req = 1, to survive. The second pair is a power-down write and the spi_mode flag. That write clears the flag in the middle of a frame, while cs_n is still low. The bench then checks that only the next falling edge of cs_n sets the flag again. A behavioural model of the register, the pointer and the flag is compared with the outputs on every clock, and read bits are compared at each rising sck edge.

// File: rtl/cp_pkg.sv
package cp_pkg;

    typedef enum logic [2:0] {
        ST_HDR  = 3'd0,
        ST_PTR  = 3'd1,
        ST_WR   = 3'd2,
        ST_RD   = 3'd3,
        ST_SKIP = 3'd4
    } frame_st_e;

endpackage

// File: rtl/cp_mode_latch.sv
module cp_mode_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic clr,
    output logic spi_mode
);

    typedef struct packed {
        logic cs_prev;
        logic mode;
    } latch_t;

    latch_t q, d;
    logic   cs_fall;

    always_comb begin
        d         = q;
        cs_fall   = q.cs_prev && !cs_n;
        d.cs_prev = cs_n;
        if (clr) begin
            d.mode = 1'b0;
        end
        if (cs_fall) begin
            d.mode = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.cs_prev <= 1'b1;
            q.mode    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign spi_mode = q.mode;

    assert_sel_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cs_prev && !cs_n) |=> spi_mode);

    assert_sel_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_mode && !clr) |=> spi_mode);

    assert_sel_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !(q.cs_prev && !cs_n)) |=> !spi_mode);

endmodule

// File: rtl/cp_regfile.sv
module cp_regfile #(
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 3,
    parameter int CTRL_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              cal_done,
    output logic [DATA_W-1:0] ctrl,
    output logic              pdn_rise
);

    localparam int CAL_BIT = DATA_W - 1;
    localparam int PDN_BIT = 0;
    localparam logic [ADDR_W-1:0] CTRL_A   = ADDR_W'(CTRL_ADDR);
    localparam logic [DATA_W-1:0] CTRL_RST = DATA_W'(1);

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
    } rf_t;

    rf_t  q, d;
    logic wr_hit;

    always_comb begin
        d        = q;
        wr_hit   = wr_en && (wr_addr == CTRL_A);
        pdn_rise = wr_hit && wr_data[PDN_BIT] && !q.ctrl[PDN_BIT];
        if (cal_done) begin
            d.ctrl[CAL_BIT] = 1'b0;
        end
        if (wr_hit) begin
            d.ctrl = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.ctrl <= CTRL_RST;
        end else begin
            q <= d;
        end
    end

    assign ctrl    = q.ctrl;
    assign rd_data = (rd_addr == CTRL_A) ? q.ctrl : '0;

    assert_cal_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_done && !wr_hit) |=> !ctrl[CAL_BIT]);

    assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && wr_data[CAL_BIT]) |=> ctrl[CAL_BIT]);

    assert_other_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hit) |=> (ctrl[CAL_BIT-1:0] == $past(ctrl[CAL_BIT-1:0])));

endmodule

// File: rtl/cp_frame.sv
module cp_frame
    import cp_pkg::*;
#(
    parameter int          DATA_W    = 8,
    parameter int          ADDR_W    = 3,
    parameter int          CHIP_W    = 7,
    parameter logic [6:0]  CHIP_ADDR = 7'b0010000,
    parameter int          PTR_RST   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              mosi,
    output logic              miso,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data
);

    localparam int             CNT_W   = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DATA_W - 1);

    typedef struct packed {
        logic              sck_prev;
        frame_st_e         st;
        logic [CNT_W-1:0]  bit_cnt;
        logic [DATA_W-1:0] rx;
        logic [ADDR_W-1:0] ptr;
        logic              incr;
        logic [DATA_W-1:0] tx;
        logic [CNT_W-1:0]  tx_cnt;
        logic              miso;
    } fr_t;

    fr_t               q, d;
    logic              rise, fall;
    logic              reload;
    logic [DATA_W-1:0] byte_v;
    logic [ADDR_W-1:0] ptr_inc, ptr_next;

    assign rise     = sck && !q.sck_prev;
    assign fall     = !sck && q.sck_prev;
    assign ptr_inc  = q.ptr + 1'b1;
    assign ptr_next = q.incr ? ptr_inc : q.ptr;
    assign reload   = !cs_n && fall && (q.st == ST_RD) && (q.tx_cnt == CNT_MAX);
    assign rd_addr  = reload ? ptr_next : q.ptr;
    assign byte_v   = {q.rx[DATA_W-2:0], mosi};

    always_comb begin
        d          = q;
        d.sck_prev = sck;
        wr_en      = 1'b0;
        wr_addr    = q.ptr;
        wr_data    = byte_v;
        if (cs_n) begin
            d.st      = ST_HDR;
            d.bit_cnt = '0;
            d.tx_cnt  = '0;
            d.miso    = 1'b0;
        end else begin
            if (rise && q.st != ST_RD && q.st != ST_SKIP) begin
                d.rx      = byte_v;
                d.bit_cnt = q.bit_cnt + 1'b1;
                if (q.bit_cnt == CNT_MAX) begin
                    d.bit_cnt = '0;
                    case (q.st)
                        ST_HDR: begin
                            if (byte_v[DATA_W-1 -: CHIP_W] == CHIP_ADDR) begin
                                if (byte_v[0]) begin
                                    d.st     = ST_RD;
                                    d.tx     = rd_data;
                                    d.tx_cnt = '0;
                                end else begin
                                    d.st = ST_PTR;
                                end
                            end else begin
                                d.st = ST_SKIP;
                            end
                        end
                        ST_PTR: begin
                            d.incr = byte_v[DATA_W-1];
                            d.ptr  = byte_v[ADDR_W-1:0];
                            d.st   = ST_WR;
                        end
                        ST_WR: begin
                            wr_en = 1'b1;
                            d.ptr = ptr_next;
                        end
                        default: begin
                            d.st = q.st;
                        end
                    endcase
                end
            end
            if (fall && q.st == ST_RD) begin
                d.miso   = q.tx[DATA_W-1];
                d.tx     = {q.tx[DATA_W-2:0], 1'b0};
                d.tx_cnt = q.tx_cnt + 1'b1;
                if (reload) begin
                    d.ptr = ptr_next;
                    d.tx  = rd_data;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q          <= '0;
            q.st       <= ST_HDR;
            q.ptr      <= ADDR_W'(PTR_RST);
        end else begin
            q <= d;
        end
    end

    assign miso = q.miso;

    assert_miso_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !miso);

    assert_skip_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SKIP && !cs_n) |=> (q.st == ST_SKIP && !wr_en && !miso));

    assert_write_only_framed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (!cs_n && $rose(sck)));

endmodule

// File: rtl/ctl_spi_regbank.sv
module ctl_spi_regbank #(
    parameter int         DATA_W    = 8,
    parameter int         ADDR_W    = 3,
    parameter int         CTRL_ADDR = 1,
    parameter logic [6:0] CHIP_ADDR = 7'b0010000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              mosi,
    input  logic              cal_done,
    output logic              miso,
    output logic              spi_mode,
    output logic              cal_req,
    output logic              mute_ctl,
    output logic [DATA_W-4:0] mode_sel,
    output logic              pdn
);

    localparam int CHIP_W = DATA_W - 1;

    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] ctrl;
    logic              pdn_rise;

    cp_frame #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .CHIP_W   (CHIP_W),
        .CHIP_ADDR(CHIP_ADDR),
        .PTR_RST  (CTRL_ADDR)
    ) u_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .sck    (sck),
        .mosi   (mosi),
        .miso   (miso),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    cp_regfile #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .CTRL_ADDR(CTRL_ADDR)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .cal_done(cal_done),
        .ctrl    (ctrl),
        .pdn_rise(pdn_rise)
    );

    cp_mode_latch u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .clr     (pdn_rise),
        .spi_mode(spi_mode)
    );

    assign cal_req  = ctrl[DATA_W-1];
    assign mute_ctl = ctrl[DATA_W-2];
    assign mode_sel = ctrl[DATA_W-3:1];
    assign pdn      = ctrl[0];

endmodule

// File: tb/tb_ctl_spi_regbank.sv
`timescale 1ns/1ps
module tb_ctl_spi_regbank;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sck = 1'b0;
    logic       mosi = 1'b0;
    logic       cal_done = 1'b0;
    logic       miso, spi_mode, cal_req, mute_ctl, pdn;
    logic [4:0] mode_sel;

    int   n_checks = 0;
    int   n_err = 0;
    bit   cmp_en = 1'b0;
    bit   done_flag = 1'b0;

    logic [7:0] exp_ctrl = 8'h01;
    logic       exp_mode = 1'b0;
    logic [2:0] exp_ptr = 3'd1;
    logic       exp_incr = 1'b0;

    localparam logic [6:0] CHIP = 7'b0010000;

    always #4 clk = ~clk;

    ctl_spi_regbank dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .cal_done(cal_done), .miso(miso), .spi_mode(spi_mode),
        .cal_req(cal_req), .mute_ctl(mute_ctl), .mode_sel(mode_sel), .pdn(pdn)
    );

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] model_rd(input logic [2:0] a);
        return (a == 3'd1) ? exp_ctrl : 8'h00;
    endfunction

    // Per-clock comparison of register fields and the selection flag
    always @(negedge clk) begin
        if (cmp_en) begin
            check8("R3 fields", {cal_req, mute_ctl, mode_sel, pdn}, exp_ctrl);
            check8("R2 spi_mode", {7'd0, spi_mode}, {7'd0, exp_mode});
            if (cs_n) check8("R12 miso idle", {7'd0, miso}, 8'h00);
        end
    end

    // kind: 0 none, 1 pointer byte, 2 data write
    task automatic model_commit(input int kind, input logic [7:0] b, input logic done);
        bit hit;
        hit = (kind == 2) && (exp_ptr == 3'd1);
        if (done && !hit) exp_ctrl[7] = 1'b0;
        if (kind == 1) begin
            exp_incr = b[7];
            exp_ptr  = b[2:0];
        end else if (kind == 2) begin
            if (hit) begin
                if (!exp_ctrl[0] && b[0]) exp_mode = 1'b0;
                exp_ctrl = b;
            end
            if (exp_incr) exp_ptr = exp_ptr + 3'd1;
        end
    endtask

    task automatic xfer(input logic [7:0] tx, input int kind, input logic done_last,
                        output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk) mosi = tx[i];
            @(negedge clk);
            rx[i] = miso;
            sck = 1'b1;
            if (i == 0) cal_done = done_last;
            @(posedge clk);
            if (i == 0) model_commit(kind, tx, done_last);
            @(negedge clk) cal_done = 1'b0;
            @(negedge clk) sck = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic cs_fall();
        @(negedge clk) cs_n = 1'b0;
        @(posedge clk) exp_mode = 1'b1;
    endtask

    task automatic cs_rise();
        @(negedge clk) cs_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic write_frame(input logic [6:0] chip, input logic [7:0] ptrb,
                               input logic [7:0] d0, input logic [7:0] d1,
                               input int n, input logic done_last);
        logic [7:0] rx;
        bit ok;
        ok = (chip == CHIP);
        cs_fall();
        xfer({chip, 1'b0}, 0, 1'b0, rx);
        xfer(ptrb, ok ? 1 : 0, 1'b0, rx);
        if (n > 0) xfer(d0, ok ? 2 : 0, (n == 1) ? done_last : 1'b0, rx);
        if (n > 1) xfer(d1, ok ? 2 : 0, done_last, rx);
        cs_rise();
    endtask

    task automatic read_frame(input logic [6:0] chip, input int n, input string tag);
        logic [7:0] rx;
        logic [7:0] expv;
        bit ok;
        ok = (chip == CHIP);
        cs_fall();
        xfer({chip, 1'b1}, 0, 1'b0, rx);
        for (int k = 0; k < n; k++) begin
            expv = ok ? model_rd(exp_ptr) : 8'h00;
            xfer(8'h00, 0, 1'b0, rx);
            check8(tag, rx, expv);
            if (ok && exp_incr) exp_ptr = exp_ptr + 3'd1;
        end
        cs_rise();
    endtask

    task automatic pulse_done();
        @(negedge clk) cal_done = 1'b1;
        @(posedge clk) exp_ctrl[7] = 1'b0;
        @(negedge clk) cal_done = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check8("R1 ctrl reset", {cal_req, mute_ctl, mode_sel, pdn}, 8'h01);
        check8("R1 spi_mode reset", {7'd0, spi_mode}, 8'h00);
        check8("R1 miso reset", {7'd0, miso}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_en = 1'b1;
        // R1: pointer resets to 1, read returns reset value
        read_frame(CHIP, 1, "R1 reset pointer read");
        // R2: flag sticky after cs rise
        repeat (5) @(negedge clk);
        check8("R2 sticky flag", {7'd0, spi_mode}, 8'h01);
        // R3: write control register
        write_frame(CHIP, 8'h01, 8'h5A, 8'h00, 1, 1'b0);
        check8("R3 mode_sel field", {3'd0, mode_sel}, 8'h0D);
        check8("R3 mute field", {7'd0, mute_ctl}, 8'h01);
        // R4: wrong chip address, write and read
        write_frame(7'b0010001, 8'h01, 8'hFF, 8'hFF, 2, 1'b0);
        check8("R4 ignored write", {cal_req, mute_ctl, mode_sel, pdn}, 8'h5A);
        read_frame(7'b1010000, 2, "R4 miso quiet");
        // R5: read back
        read_frame(CHIP, 2, "R5 read MSB first");
        // R6: no increment, second byte overwrites
        write_frame(CHIP, 8'h01, 8'h33, 8'h5C, 2, 1'b0);
        check8("R6 same address", {cal_req, mute_ctl, mode_sel, pdn}, 8'h5C);
        // R6/R7: increment from address 0 to 1
        write_frame(CHIP, 8'h80, 8'hAA, 8'h3E, 2, 1'b0);
        check8("R6 increment write", {cal_req, mute_ctl, mode_sel, pdn}, 8'h3E);
        // R7: wrap 7 -> 0 -> 1 on read
        write_frame(CHIP, 8'h87, 8'h00, 8'h00, 0, 1'b0);
        read_frame(CHIP, 3, "R7 wrap and zero reads");
        // R11: reserved pointer bits ignored
        write_frame(CHIP, 8'h79, 8'h44, 8'h46, 2, 1'b0);
        check8("R11 reserved bits", {cal_req, mute_ctl, mode_sel, pdn}, 8'h46);
        // R8: calibration request cleared by done pulse
        write_frame(CHIP, 8'h01, 8'hC6, 8'h00, 1, 1'b0);
        check8("R8 cal set", {7'd0, cal_req}, 8'h01);
        pulse_done();
        @(negedge clk);
        check8("R8 cal cleared", {cal_req, mute_ctl, mode_sel, pdn}, 8'h46);
        // R9: write and done in same clock
        write_frame(CHIP, 8'h01, 8'h86, 8'h00, 1, 1'b1);
        check8("R9 write wins", {7'd0, cal_req}, 8'h01);
        pulse_done();
        // R10: pdn 0 -> 1 clears flag
        write_frame(CHIP, 8'h01, 8'h07, 8'h00, 1, 1'b0);
        check8("R10 flag cleared", {7'd0, spi_mode}, 8'h00);
        write_frame(CHIP, 8'h01, 8'h07, 8'h00, 1, 1'b0);
        check8("R10 flag kept", {7'd0, spi_mode}, 8'h01);
        read_frame(CHIP, 1, "R5 final read");
        repeat (4) @(negedge clk);
        cmp_en = 1'b0;
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done_flag) begin
            done_flag = 1'b1;
            n_checks++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

endmodule